// File: doc/BRIEF.md
# Masked Associative Search Memory

This block is a small content addressable memory whose entries are 64 bits wide. A host reaches it through a 16-bit request port. The host uses this port to assemble a comparand, two mask words, a write buffer and a control word, and to store or read back entries. Each entry carries a 2-bit validity code. Only entries whose code is Valid take part in a search. The other three codes park an entry: it is either unused, temporarily skipped, or kept as plain storage (for example, a spare mask value).

A search compares the comparand against every Valid entry in parallel. It reports a hit flag, a multiple-hit flag and the address of the lowest-numbered hit. It also returns the bits of the hit entry that the active compare mask excludes from the search. Because of this, one stored word can be split at any bit position into a key part and an associated-data part. A search starts without any command when the last lane of the comparand or of a mask is written, or when the control word is written. It can also be started by an explicit search request. The second mask can instead protect bits during entry writes.

The request port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The block drops `req_ready` for exactly one cycle after it accepts a request that starts a search. The host must hold its request stable until it is accepted. Results and read data are plain registered outputs.

Top module: `masked_cam`

## Requirements
- R1: After reset every entry holds validity code Empty (2'b01) and data zero, both masks and the control word are zero, `res_match`, `res_multi` and `res_valid` are low, and `req_ready` is high.
- R2: Comparand (op 0) and mask (op 1, `req_sel` picks mask 0 or 1) words are loaded in four 16-bit lanes, where lane n sets bits 16n+15..16n. Writing lane 3 of either word starts a search, and writing the control word (op 2) also starts one.
- R3: An explicit search request (op 5) starts a search using the current comparand, masks and control word.
- R4: Only entries with code Valid (2'b00) can hit. Entries with code Empty (01), Skip (10) or RAM (11) never hit.
- R5: `res_addr` is the lowest-numbered hit entry. `res_multi` is high only when two or more entries hit. With no hit, `res_match` is low and `res_addr` is 0.
- R6: Control bit 0 enables the compare mask and bit 1 selects it (0 = mask 0, 1 = mask 1). A mask bit of 1 excludes that bit from the comparison. When bit 0 is clear, all 64 bits are compared.
- R7: `res_assoc` equals the hit entry's data ANDed with the active compare mask. It is zero when there is no hit.
- R8: Control bit 2 enables the write mask and bit 3 selects it. During an entry write (op 4), bits set in the active write mask keep their old value, and all other bits take the write buffer (op 3, loaded in lanes).
- R9: An entry write stores `req_data[1:0]` as the validity code at `req_addr`. A read (op 6) presents that entry's word and code on `rd_word`/`rd_state` after the accepting edge, including entries in the RAM state.
- R10: The search result appears one clock after the edge that accepts the triggering request, with a one-cycle `res_valid` pulse. `req_ready` is low during that clock. The result outputs hold their values until the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Operation: 0 comparand, 1 mask, 2 control, 3 write buffer, 4 entry write, 5 search, 6 read, 7 none |
| req_addr | input | 6 | Entry address for write and read |
| req_lane | input | 2 | 16-bit lane of the 64-bit word being loaded |
| req_sel | input | 1 | Mask select for op 1 |
| req_data | input | 16 | Lane data, control bits, or validity code |
| res_valid | output | 1 | One-cycle pulse when a search result is updated |
| res_match | output | 1 | At least one Valid entry hit |
| res_multi | output | 1 | Two or more Valid entries hit |
| res_addr | output | 6 | Lowest hit address |
| res_assoc | output | 64 | Masked-off bits of the hit entry |
| rd_word | output | 64 | Data of the entry last read |
| rd_state | output | 2 | Validity code of the entry last read |

## Verification
The bench places identical data in entries whose codes it then changes between Valid, Empty, RAM and Skip. A design that searched non-Valid entries would report a wrong address or a false multiple hit. Two hits at addresses 9 and 20 that differ only in a masked byte check the lowest-address priority, the multiple-hit flag, and mask selection. A design that ignored the enable or select bit would report a single hit. A masked entry write checks that protected lanes keep their old value while unmasked lanes change. The bench also checks that the ready signal falls in the one cycle after a search request, which would be missed by a design that accepted a request while its result was still pending.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [2:0] {
    OP_CMP    = 3'd0,
    OP_MASK   = 3'd1,
    OP_CTRL   = 3'd2,
    OP_WBUF   = 3'd3,
    OP_WRITE  = 3'd4,
    OP_SEARCH = 3'd5,
    OP_READ   = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_VALID = 2'd0,
    ST_EMPTY = 2'd1,
    ST_SKIP  = 2'd2,
    ST_RAM   = 2'd3
  } vstate_e;

  typedef struct packed {
    logic wm_sel;
    logic wm_en;
    logic cm_sel;
    logic cm_en;
  } ctrl_t;
endpackage

// File: rtl/cam_regs.sv
module cam_regs
  import cam_pkg::*;
#(
  parameter int W  = 64,
  parameter int BW = 16,
  localparam int LANES = W / BW,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    op,
  input  logic [LW-1:0] lane,
  input  logic          sel,
  input  logic [BW-1:0] data,
  output logic [W-1:0]  cmp_word,
  output logic [W-1:0]  cmp_mask,
  output logic [W-1:0]  wr_mask,
  output logic [W-1:0]  wbuf,
  output logic          trig
);
  logic [W-1:0] cmp_q, wbuf_q;
  logic [W-1:0] mask_q [2];
  ctrl_t        ctrl_q;
  logic         last_lane;

  assign last_lane = (lane == LW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q     <= '0;
      wbuf_q    <= '0;
      mask_q[0] <= '0;
      mask_q[1] <= '0;
      ctrl_q    <= '0;
    end else if (wr_en) begin
      case (op_e'(op))
        OP_CMP:  cmp_q[lane*BW +: BW] <= data;
        OP_MASK: mask_q[sel][lane*BW +: BW] <= data;
        OP_WBUF: wbuf_q[lane*BW +: BW] <= data;
        OP_CTRL: ctrl_q <= ctrl_t'(data[3:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    trig = 1'b0;
    if (wr_en) begin
      if ((op_e'(op) == OP_CMP || op_e'(op) == OP_MASK) && last_lane) trig = 1'b1;
      if (op_e'(op) == OP_CTRL) trig = 1'b1;
    end
  end

  assign cmp_word = cmp_q;
  assign wbuf     = wbuf_q;
  assign cmp_mask = ctrl_q.cm_en ? mask_q[ctrl_q.cm_sel] : '0;
  assign wr_mask  = ctrl_q.wm_en ? mask_q[ctrl_q.wm_sel] : '0;
endmodule

// File: rtl/cam_array.sv
module cam_array
  import cam_pkg::*;
#(
  parameter int W     = 64,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     wmask,
  input  logic [1:0]       wstate,
  input  logic [W-1:0]     cmp_word,
  input  logic [W-1:0]     cmp_mask,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_word,
  output logic [1:0]       rd_state,
  input  logic [AW-1:0]    hit_addr,
  output logic [W-1:0]     hit_word,
  output logic [DEPTH-1:0] hit
);
  logic [W-1:0] mem [DEPTH];
  logic [1:0]   st  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[i] <= '0;
        st[i]  <= ST_EMPTY;
      end else if (we && waddr == AW'(i)) begin
        mem[i] <= (mem[i] & wmask) | (wdata & ~wmask);
        st[i]  <= wstate;
      end
    end
    assign hit[i] = (st[i] == ST_VALID) && (((mem[i] ^ cmp_word) & ~cmp_mask) == '0);
  end

  assign rd_word  = mem[rd_addr];
  assign rd_state = st[rd_addr];
  assign hit_word = mem[hit_addr];
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] hit,
  output logic             any,
  output logic             multi,
  output logic [AW-1:0]    idx
);
  always_comb begin
    any   = 1'b0;
    multi = 1'b0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) begin
        if (any) multi = 1'b1;
        else begin
          any = 1'b1;
          idx = AW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int W     = 64,
  parameter int BW    = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(W / BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_lane,
  input  logic          req_sel,
  input  logic [BW-1:0] req_data,
  output logic          res_valid,
  output logic          res_match,
  output logic          res_multi,
  output logic [AW-1:0] res_addr,
  output logic [W-1:0]  res_assoc,
  output logic [W-1:0]  rd_word,
  output logic [1:0]    rd_state
);
  logic             acc, auto_trig, trig, pend_q;
  logic [W-1:0]     cmp_word, cmp_mask, wr_mask, wbuf;
  logic [W-1:0]     arr_rd_word, hit_word;
  logic [1:0]       arr_rd_state;
  logic [DEPTH-1:0] hit;
  logic             any, multi;
  logic [AW-1:0]    idx;

  assign req_ready = !pend_q;
  assign acc       = req_valid && req_ready;
  assign trig      = auto_trig || (acc && op_e'(req_op) == OP_SEARCH);

  cam_regs #(.W(W), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(acc), .op(req_op), .lane(req_lane),
    .sel(req_sel), .data(req_data), .cmp_word(cmp_word), .cmp_mask(cmp_mask),
    .wr_mask(wr_mask), .wbuf(wbuf), .trig(auto_trig)
  );

  cam_array #(.W(W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .rst_n(rst_n), .we(acc && op_e'(req_op) == OP_WRITE),
    .waddr(req_addr), .wdata(wbuf), .wmask(wr_mask), .wstate(req_data[1:0]),
    .cmp_word(cmp_word), .cmp_mask(cmp_mask), .rd_addr(req_addr),
    .rd_word(arr_rd_word), .rd_state(arr_rd_state), .hit_addr(idx),
    .hit_word(hit_word), .hit(hit)
  );

  cam_prio #(.DEPTH(DEPTH)) u_prio (.hit(hit), .any(any), .multi(multi), .idx(idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      res_valid <= 1'b0;
      res_match <= 1'b0;
      res_multi <= 1'b0;
      res_addr  <= '0;
      res_assoc <= '0;
      rd_word   <= '0;
      rd_state  <= ST_EMPTY;
    end else begin
      pend_q    <= trig;
      res_valid <= pend_q;
      if (pend_q) begin
        res_match <= any;
        res_multi <= multi;
        res_addr  <= idx;
        res_assoc <= any ? (hit_word & cmp_mask) : '0;
      end
      if (acc && op_e'(req_op) == OP_READ) begin
        rd_word  <= arr_rd_word;
        rd_state <= arr_rd_state;
      end
    end
  end
endmodule

// File: rtl/cam_check.sv
module cam_check #(
  parameter int W  = 64,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic          res_valid,
  input logic          res_match,
  input logic          res_multi,
  input logic [AW-1:0] res_addr,
  input logic [W-1:0]  res_assoc
);
  AST_SEARCH_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd5) |=> !req_ready); // R10
  AST_SEARCH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd5) |-> ##2 res_valid); // R3
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_match) && $stable(res_multi) && $stable(res_addr))); // R10
  AST_MULTI_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_multi |-> res_match); // R5
  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_match |-> res_addr == '0); // R5
  AST_MISS_NO_ASSOC: assert property (@(posedge clk) disable iff (!rst_n)
    !res_match |-> res_assoc == '0); // R7
endmodule

bind masked_cam cam_check #(.W(W), .AW(AW)) i_cam_check (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .res_valid(res_valid), .res_match(res_match),
  .res_multi(res_multi), .res_addr(res_addr), .res_assoc(res_assoc)
);

// File: tb/test_masked_cam.sv
module test_masked_cam;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd7;
  logic [5:0]  req_addr = '0;
  logic [1:0]  req_lane = '0;
  logic        req_sel = 1'b0;
  logic [15:0] req_data = '0;
  logic        res_valid, res_match, res_multi;
  logic [5:0]  res_addr;
  logic [63:0] res_assoc, rd_word;
  logic [1:0]  rd_state;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  masked_cam i_masked_cam (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_lane(req_lane), .req_sel(req_sel),
    .req_data(req_data), .res_valid(res_valid), .res_match(res_match),
    .res_multi(res_multi), .res_addr(res_addr), .res_assoc(res_assoc),
    .rd_word(rd_word), .rd_state(rd_state)
  );

  // op, addr, lane, sel, data, check, exp match, exp multi, exp addr
  localparam int NV = 27;
  localparam logic [36:0] VEC [NV] = '{
    {3'd3, 6'd0,  2'd0, 1'b0, 16'h4444, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd3, 6'd0,  2'd1, 1'b0, 16'h3333, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd3, 6'd0,  2'd2, 1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd3, 6'd0,  2'd3, 1'b0, 16'h1111, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd4, 6'd5,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd4, 6'd9,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd4, 6'd12, 2'd0, 1'b0, 16'h0002, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd0, 6'd0,  2'd0, 1'b0, 16'h4444, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd0, 6'd0,  2'd1, 1'b0, 16'h3333, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd0, 6'd0,  2'd2, 1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd0, 6'd0,  2'd3, 1'b0, 16'h1111, 1'b1, 1'b1, 1'b1, 6'd5},
    {3'd4, 6'd5,  2'd0, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd5, 6'd0,  2'd0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd9},
    {3'd4, 6'd9,  2'd0, 1'b0, 16'h0003, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd5, 6'd0,  2'd0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 6'd0},
    {3'd4, 6'd9,  2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd5, 6'd0,  2'd0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd9},
    {3'd3, 6'd0,  2'd0, 1'b0, 16'h4455, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd4, 6'd20, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd5, 6'd0,  2'd0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd9},
    {3'd1, 6'd0,  2'd0, 1'b0, 16'h00FF, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd1, 6'd0,  2'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd1, 6'd0,  2'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'd0},
    {3'd1, 6'd0,  2'd3, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd9},
    {3'd2, 6'd0,  2'd0, 1'b0, 16'h0001, 1'b1, 1'b1, 1'b1, 6'd9},
    {3'd2, 6'd0,  2'd0, 1'b0, 16'h0003, 1'b1, 1'b1, 1'b0, 6'd9},
    {3'd2, 6'd0,  2'd0, 1'b0, 16'h0001, 1'b1, 1'b1, 1'b1, 6'd9}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [5:0] addr, input logic [1:0] lane,
                      input logic sel, input logic [15:0] data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = addr; req_lane = lane; req_sel = sel; req_data = data;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_op = 3'd7;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    check(res_match == 1'b0 && res_multi == 1'b0 && res_valid == 1'b0, "R1 flags",
          {61'd0, res_valid, res_multi, res_match}, 64'd0);
    send(3'd6, 6'd0, 2'd0, 1'b0, 16'h0);
    check(rd_state == 2'd1 && rd_word == 64'd0, "R1 entry empty", {rd_state, rd_word[61:0]}, {2'd1, 62'd0});

    // Table: R2 lane-3 and control triggers, R3 explicit search, R4 states, R5 priority, R6 mask select
    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      e = VEC[v];
      send(e[36:34], e[33:28], e[27:26], e[25], e[24:9]);
      if (e[8]) begin
        @(negedge clk);
        check(res_valid && res_match == e[7] && res_multi == e[6] && res_addr == e[5:0],
              $sformatf("R2/R3/R4/R5/R6 vector %0d", v),
              {54'd0, res_valid, res_match, res_multi, res_addr, 1'b0},
              {54'd0, 1'b1, e[7], e[6], e[5:0], 1'b0});
      end
    end

    // R7: masked byte of the hit entry comes back as associated data
    send(3'd5, 6'd0, 2'd0, 1'b0, 16'h0);
    // R10: ready is low in the cycle after a search is accepted
    check(req_ready == 1'b0, "R10 hold-off", 64'(req_ready), 64'd0);
    @(negedge clk);
    check(res_valid == 1'b1, "R10 result pulse", 64'(res_valid), 64'd1);
    check(res_assoc == 64'h44, "R7 assoc data", res_assoc, 64'h44);
    @(negedge clk);
    check(res_valid == 1'b0 && res_addr == 6'd9, "R10 pulse ends, result held",
          {57'd0, res_valid, res_addr}, {57'd0, 1'b0, 6'd9});

    // R8: write mask 1 protects lane 0
    send(3'd1, 6'd0, 2'd0, 1'b1, 16'hFFFF);
    send(3'd1, 6'd0, 2'd1, 1'b1, 16'h0000);
    send(3'd1, 6'd0, 2'd2, 1'b1, 16'h0000);
    send(3'd1, 6'd0, 2'd3, 1'b1, 16'h0000);
    send(3'd2, 6'd0, 2'd0, 1'b0, 16'h000D);
    send(3'd3, 6'd0, 2'd0, 1'b0, 16'h0000);
    send(3'd3, 6'd0, 2'd1, 1'b0, 16'hAAAA);
    send(3'd4, 6'd9, 2'd0, 1'b0, 16'h0000);
    send(3'd6, 6'd9, 2'd0, 1'b0, 16'h0);
    check(rd_word == 64'h1111_2222_AAAA_4444, "R8 masked write", rd_word, 64'h1111_2222_AAAA_4444);

    // R9: entry in RAM state is stored and read back
    send(3'd4, 6'd30, 2'd0, 1'b0, 16'h0003);
    send(3'd6, 6'd30, 2'd0, 1'b0, 16'h0);
    check(rd_state == 2'd3, "R9 RAM state", 64'(rd_state), 64'd3);
    check(rd_word == 64'h1111_2222_AAAA_0000, "R9 RAM word", rd_word, 64'h1111_2222_AAAA_0000);

    // R4: comparand equal to the RAM entry with mask off still gives no hit at 30
    send(3'd2, 6'd0, 2'd0, 1'b0, 16'h0000);
    send(3'd0, 6'd0, 2'd0, 1'b0, 16'h0000);
    send(3'd0, 6'd0, 2'd1, 1'b0, 16'hAAAA);
    send(3'd0, 6'd0, 2'd2, 1'b0, 16'h2222);
    send(3'd0, 6'd0, 2'd3, 1'b0, 16'h1111);
    @(negedge clk);
    check(res_valid && !res_match && res_addr == 6'd0, "R4 RAM entry not searched",
          {56'd0, res_valid, res_match, res_addr}, {56'd0, 1'b1, 1'b0, 6'd0});
    finish_run();
  end
endmodule